// File: doc/BRIEF.md
# Masked Row Readback CRC32 Accumulator

This block builds a 32-bit CRC signature over the configuration rows that a programmable device returns on readback. Each row arrives serially, one bit per accepted cycle, least significant bit first. A row-start strobe opens each row and carries a small selector that picks one stored row mask. Each data bit is ANDed with the mask bit at the same position before it enters the CRC. This zeroes the readback bits that carry no meaning.

Rows are 274 bits long. The CRC treats each row as if it were padded with zeros to a whole number of bytes (280 bits). The block folds those six zero bits into the remainder itself, in the same cycle as the row's last data bit, so the sender never has to supply them. The CRC is the common reflected CRC-32. When the 98th row is complete, the block raises a done flag. The result then stays frozen until software issues the next start pulse. Masks are loaded through a write port, one whole row mask per write.

Top module: `masked_row_crc`

## Requirements
- R1: While reset is held low, `done` reads 0 and `crc_out` reads 0 from the next clock, and every mask entry is cleared to all zeros.
- R2: A write with `mask_wr_en` high stores `mask_wr_data` into entry `mask_wr_idx`. Rows read the new mask from the following cycle on. A write to an index of 6 or 7 stores nothing.
- R3: Every accepted bit is ANDed with the bit of the selected mask at the same row position before it enters the CRC. Row position p, counted from 0 for the first bit of the row, uses bit p of the mask word.
- R4: The CRC is reflected, with polynomial 0xEDB88320. The remainder starts at 0xFFFFFFFF. Each bit is XORed into remainder bit 0, the remainder shifts right by one, and the polynomial is XORed in when the bit shifted out was 1. The output `crc_out` is the remainder XOR 0xFFFFFFFF.
- R5: On the cycle that accepts the 274th bit of a row, the block also shifts six zero bits into the CRC. Each row therefore contributes 35 whole bytes.
- R6: A cycle with `bit_valid` low leaves the remainder, and hence `crc_out`, unchanged.
- R7: A `row_start` opens a row and latches `row_sel`. A valid bit in the same cycle is bit 0 of that row and is masked with the new `row_sel`.
- R8: Valid bits are ignored while no row is open. This covers bits sent after a start pulse but before the first `row_start`, and bits sent after a row's 274th bit but before the next `row_start`.
- R9: A selector value of 6 or 7 selects an all-zero mask.
- R10: `done` rises at the clock edge that accepts the last bit of row 98. From that edge on, `crc_out` holds the final checksum.
- R11: While `done` is high and no start is given, all data, row and mask-select inputs are ignored, and `done` and `crc_out` hold.
- R12: A `start` pulse reloads the remainder to all ones, clears `done` and the row count, and closes any open row. Other row and data inputs in the same cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a new checksum |
| mask_wr_en | input | 1 | Mask table write strobe |
| mask_wr_idx | input | 3 | Mask entry written |
| mask_wr_data | input | 274 | Mask word, bit p covers row position p |
| row_start | input | 1 | Opens a row |
| row_sel | input | 3 | Mask selector for the row being opened |
| bit_valid | input | 1 | `bit_data` carries a row bit this cycle |
| bit_data | input | 1 | Serial row bit |
| crc_out | output | 32 | Remainder after the final XOR |
| done | output | 1 | All rows have been consumed |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:
- Row edges. Bit 0 can arrive together with `row_start` or on a later cycle. A design that mishandles this either loses bit 0 or masks it with the previous row's selector.
- Pad folding. A design that drops the six pad zeros, or adds them one cycle late, produces a wrong signature even when every data bit is all ones.
- Ignored inputs. The bench sends stray bits outside open rows, idle gaps in the middle of rows, out-of-range selectors, and traffic after `done`. Any of these that leaks into the remainder shows up as a changed checksum.
- Mask rewrite. A mask is rewritten in the middle of a run, which exposes a table that updates early or late.
- Restart. The bench issues a start pulse in the same cycle as a row bit. A design that gives start no priority would fold that bit into the fresh checksum.

// File: rtl/masked_crc_pkg.sv
// Shared definitions for the masked row CRC block.
// Assumes a 32-bit reflected CRC; the polynomial is passed in by the caller.
package masked_crc_pkg;

    localparam int CRC_W = 32;

    typedef logic [CRC_W-1:0] crc_t;

    localparam crc_t CRC_ONES = '1;

    // One serial CRC step: fold a bit into bit 0, shift right, reduce.
    function automatic crc_t crc_step(input crc_t rem, input logic b, input crc_t poly);
        crc_t t;
        logic fb;
        t     = rem;
        t[0]  = t[0] ^ b;
        fb    = t[0];
        t     = t >> 1;
        if (fb) begin
            t = t ^ poly;
        end
        return t;
    endfunction

endpackage

// File: rtl/mrc_mask_table.sv
// Mask storage: NUM_MASKS row-wide masks written whole, read one bit at a time.
// Assumes a read index at or above NUM_MASKS means "all-zero mask".
module mrc_mask_table #(
    parameter int ROW_BITS  = 274,
    parameter int NUM_MASKS = 6,
    parameter int IDX_W     = 3,
    parameter int POS_W     = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [ROW_BITS-1:0] wr_data,
    input  logic [IDX_W-1:0]    rd_idx,
    input  logic [POS_W-1:0]    rd_pos,
    output logic                rd_bit
);

    logic [ROW_BITS-1:0] entry_q [NUM_MASKS];

    for (genvar g = 0; g < NUM_MASKS; g++) begin : g_entry
        // Hold one mask entry; cleared by reset, replaced on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                entry_q[g] <= wr_data;
            end
        end
    end

    // Select the addressed entry and position; unknown entries read as zero.
    always_comb begin
        rd_bit = 1'b0;
        for (int k = 0; k < NUM_MASKS; k++) begin
            if ((rd_idx == IDX_W'(k)) && (rd_pos < POS_W'(ROW_BITS))) begin
                rd_bit = entry_q[k][rd_pos];
            end
        end
    end

endmodule

// File: rtl/mrc_row_seq.sv
// Row sequencer: tracks the open row, bit position, selector and row count,
// decides which input bits are accepted, and raises done after the last row.
// Assumes start has priority over every other input and done freezes intake.
module mrc_row_seq #(
    parameter int ROW_BITS = 274,
    parameter int NUM_ROWS = 98,
    parameter int IDX_W    = 3,
    parameter int POS_W    = 9,
    parameter int ROW_W    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             row_start,
    input  logic [IDX_W-1:0] row_sel,
    input  logic             bit_valid,
    output logic             take,
    output logic             last_bit,
    output logic [POS_W-1:0] cur_pos,
    output logic [IDX_W-1:0] cur_sel,
    output logic             done
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(ROW_BITS - 1);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);

    logic             open_q;
    logic [POS_W-1:0] pos_q;
    logic [IDX_W-1:0] sel_q;
    logic [ROW_W-1:0] row_cnt_q;
    logic             done_q;
    logic             active;
    logic             opening;
    logic             final_row;

    // Decode this cycle's intake: which position and selector apply, and whether the bit counts.
    always_comb begin
        active    = !start && !done_q;
        opening   = active && row_start;
        cur_pos   = opening ? '0 : pos_q;
        cur_sel   = opening ? row_sel : sel_q;
        take      = active && bit_valid && (opening || open_q);
        last_bit  = (cur_pos == LAST_POS);
        final_row = (row_cnt_q == LAST_ROW);
    end

    // Advance the row state: open, step the position, close after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            open_q    <= 1'b0;
            pos_q     <= '0;
            sel_q     <= '0;
            row_cnt_q <= '0;
        end else if (!done_q) begin
            if (opening) begin
                open_q <= 1'b1;
                sel_q  <= row_sel;
                pos_q  <= '0;
            end
            if (take) begin
                pos_q <= cur_pos + POS_W'(1);
                if (last_bit) begin
                    open_q    <= 1'b0;
                    row_cnt_q <= row_cnt_q + ROW_W'(1);
                end
            end
        end
    end

    // Raise done when the last bit of the final row is accepted; clear on start.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            done_q <= 1'b0;
        end else if (take && last_bit && final_row) begin
            done_q <= 1'b1;
        end
    end

    assign done = done_q;

endmodule

// File: rtl/mrc_crc_engine.sv
// Serial CRC engine: folds one masked bit per accepted cycle and, on a row's
// last bit, the PAD_N zero pad bits in the same cycle.
// Assumes init and bit_en are never high together in a way that matters: init wins.
module mrc_crc_engine
    import masked_crc_pkg::*;
#(
    parameter crc_t POLY  = 32'hEDB88320,
    parameter int   PAD_N = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic bit_en,
    input  logic bit_in,
    input  logic pad_en,
    output crc_t crc_out
);

    crc_t rem_q;
    crc_t after_bit;
    crc_t after_pad;

    // Fold the data bit when enabled.
    always_comb begin
        after_bit = bit_en ? crc_step(rem_q, bit_in, POLY) : rem_q;
    end

    if (PAD_N > 0) begin : g_pad
        crc_t padded;
        // Chain PAD_N zero-bit steps after the data bit.
        always_comb begin
            padded = after_bit;
            for (int k = 0; k < PAD_N; k++) begin
                padded = crc_step(padded, 1'b0, POLY);
            end
            after_pad = pad_en ? padded : after_bit;
        end
    end else begin : g_nopad
        // Rows already byte aligned: nothing to fold.
        always_comb begin
            after_pad = after_bit;
        end
    end

    // Hold the remainder; reload to all ones on reset or init.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            rem_q <= CRC_ONES;
        end else begin
            rem_q <= after_pad;
        end
    end

    assign crc_out = rem_q ^ CRC_ONES;

endmodule

// File: rtl/masked_row_crc.sv
// Top: CRC32 over serially read rows, each bit gated by a per-row mask,
// each row zero-padded to whole bytes inside the CRC.
// Assumes bits arrive LSB first within the row, row_start precedes or
// coincides with bit 0, and masks are loaded before the rows that use them.
module masked_row_crc
    import masked_crc_pkg::*;
#(
    parameter int   ROW_BITS  = 274,
    parameter int   NUM_ROWS  = 98,
    parameter int   NUM_MASKS = 6,
    parameter crc_t POLY      = 32'hEDB88320,
    localparam int  IDX_W     = (NUM_MASKS > 1) ? $clog2(NUM_MASKS) : 1,
    localparam int  CW        = CRC_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                mask_wr_en,
    input  logic [IDX_W-1:0]    mask_wr_idx,
    input  logic [ROW_BITS-1:0] mask_wr_data,
    input  logic                row_start,
    input  logic [IDX_W-1:0]    row_sel,
    input  logic                bit_valid,
    input  logic                bit_data,
    output logic [CW-1:0]       crc_out,
    output logic                done
);

    localparam int PAD_BITS = ((ROW_BITS + 7) / 8) * 8;
    localparam int PAD_N    = PAD_BITS - ROW_BITS;
    localparam int POS_W    = $clog2(ROW_BITS + 1);
    localparam int ROW_W    = $clog2(NUM_ROWS + 1);

    logic             take;
    logic             last_bit;
    logic [POS_W-1:0] cur_pos;
    logic [IDX_W-1:0] cur_sel;
    logic             mask_bit;
    logic             gated_bit;

    mrc_row_seq #(
        .ROW_BITS(ROW_BITS),
        .NUM_ROWS(NUM_ROWS),
        .IDX_W   (IDX_W),
        .POS_W   (POS_W),
        .ROW_W   (ROW_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .row_start(row_start),
        .row_sel  (row_sel),
        .bit_valid(bit_valid),
        .take     (take),
        .last_bit (last_bit),
        .cur_pos  (cur_pos),
        .cur_sel  (cur_sel),
        .done     (done)
    );

    mrc_mask_table #(
        .ROW_BITS (ROW_BITS),
        .NUM_MASKS(NUM_MASKS),
        .IDX_W    (IDX_W),
        .POS_W    (POS_W)
    ) u_masks (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (mask_wr_en),
        .wr_idx (mask_wr_idx),
        .wr_data(mask_wr_data),
        .rd_idx (cur_sel),
        .rd_pos (cur_pos),
        .rd_bit (mask_bit)
    );

    // Gate the incoming bit with its mask bit.
    always_comb begin
        gated_bit = bit_data & mask_bit;
    end

    mrc_crc_engine #(
        .POLY (POLY),
        .PAD_N(PAD_N)
    ) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .init   (start),
        .bit_en (take),
        .bit_in (gated_bit),
        .pad_en (take && last_bit),
        .crc_out(crc_out)
    );

endmodule

// File: rtl/masked_row_crc_chk.sv
// Protocol checker for masked_row_crc, attached through bind.
// Assumes only port-level behaviour; reads no internal state.
module masked_row_crc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        bit_valid,
    input logic [31:0] crc_out,
    input logic        done
);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!done && crc_out == 32'h0));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_valid && !start) |=> $stable(crc_out));

    p_done_needs_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !bit_valid && !start) |=> !done);

    p_done_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(crc_out)));

    p_start_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!done && crc_out == 32'h0));

endmodule

bind masked_row_crc masked_row_crc_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .bit_valid(bit_valid),
    .crc_out  (crc_out),
    .done     (done)
);

// File: tb/tb_masked_row_crc.sv
module tb_masked_row_crc;

    localparam int CLK_PERIOD = 10;
    localparam int ROW_BITS   = 274;
    localparam int NUM_ROWS   = 98;
    localparam int NUM_MASKS  = 6;
    localparam int IDX_W      = 3;
    localparam int ROW_BYTES  = (ROW_BITS + 7) / 8;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic                mask_wr_en = 1'b0;
    logic [IDX_W-1:0]    mask_wr_idx = '0;
    logic [ROW_BITS-1:0] mask_wr_data = '0;
    logic                row_start = 1'b0;
    logic [IDX_W-1:0]    row_sel = '0;
    logic                bit_valid = 1'b0;
    logic                bit_data = 1'b0;
    logic [31:0]         crc_out;
    logic                done;

    // next-cycle stimulus
    logic                n_rst = 1'b0;
    logic                n_start = 1'b0;
    logic                n_wr = 1'b0;
    logic [IDX_W-1:0]    n_widx = '0;
    logic [ROW_BITS-1:0] n_wdata = '0;
    logic                n_rs = 1'b0;
    logic [IDX_W-1:0]    n_sel = '0;
    logic                n_v = 1'b0;
    logic                n_d = 1'b0;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R1";

    // reference model state
    logic [ROW_BITS-1:0] m_mask [8];
    logic                m_open;
    int                  m_pos;
    int                  m_sel;
    int                  m_rows;
    logic                m_done;
    logic [31:0]         m_crc;
    logic [8*ROW_BYTES-1:0] m_row;
    logic [7:0]          m_msg[$];

    masked_row_crc dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mask_wr_en(mask_wr_en), .mask_wr_idx(mask_wr_idx), .mask_wr_data(mask_wr_data),
        .row_start(row_start), .row_sel(row_sel), .bit_valid(bit_valid), .bit_data(bit_data),
        .crc_out(crc_out), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] crc_of(input logic [7:0] q[$]);
        logic [31:0] r;
        logic fb;
        r = 32'hFFFFFFFF;
        foreach (q[i]) begin
            for (int b = 0; b < 8; b++) begin
                r[0] = r[0] ^ q[i][b];
                fb = r[0];
                r = r >> 1;
                if (fb) r = r ^ 32'hEDB88320;
            end
        end
        return r ^ 32'hFFFFFFFF;
    endfunction

    function automatic logic [ROW_BITS-1:0] mk_mask(input int k);
        logic [ROW_BITS-1:0] m;
        for (int i = 0; i < ROW_BITS; i++) begin
            case (k)
                0: m[i] = 1'b1;
                1: m[i] = 1'b0;
                2: m[i] = (i % 2) == 1;
                3: m[i] = (i % 3) != 0;
                4: m[i] = ((i / 8) % 2) == 1;
                5: m[i] = i < 137;
                default: m[i] = (i % 5) == 0;
            endcase
        end
        return m;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_update();
        if (!n_rst) begin
            for (int k = 0; k < 8; k++) m_mask[k] = '0;
            m_open = 0; m_pos = 0; m_sel = 0; m_rows = 0; m_done = 0;
            m_msg.delete();
        end else begin
            if (n_start) begin
                m_open = 0; m_pos = 0; m_sel = 0; m_rows = 0; m_done = 0;
                m_msg.delete();
            end else if (!m_done) begin
                int p;
                int s;
                p = n_rs ? 0 : m_pos;
                s = n_rs ? int'(n_sel) : m_sel;
                if (n_rs) begin
                    m_open = 1; m_sel = int'(n_sel); m_pos = 0; m_row = '0;
                end
                if (n_v && m_open) begin
                    m_row[p] = n_d & m_mask[s][p];
                    m_pos = p + 1;
                    if (p == ROW_BITS - 1) begin
                        for (int b = 0; b < ROW_BYTES; b++) m_msg.push_back(m_row[8*b +: 8]);
                        m_open = 0;
                        m_rows++;
                        if (m_rows == NUM_ROWS) begin
                            m_done = 1;
                            m_crc = crc_of(m_msg);
                        end
                    end
                end
            end
            if (n_wr && n_widx < NUM_MASKS) m_mask[n_widx] = n_wdata;
        end
    endtask

    task automatic tick();
        @(negedge clk);
        check({cur_tag, " done"}, {31'b0, done}, {31'b0, m_done});
        if (m_done) check({cur_tag, " crc"}, crc_out, m_crc);
        rst_n = n_rst; start = n_start; mask_wr_en = n_wr; mask_wr_idx = n_widx;
        mask_wr_data = n_wdata; row_start = n_rs; row_sel = n_sel; bit_valid = n_v; bit_data = n_d;
        model_update();
        n_start = 0; n_wr = 0; n_rs = 0; n_v = 0; n_d = 0;
    endtask

    // mode 0: row_start with bit 0; mode 1: row_start alone first
    task automatic send_row(input int sel, input int mode, input int ones, input bit gaps);
        if (mode == 1) begin
            n_rs = 1; n_sel = IDX_W'(sel); tick();
        end
        for (int i = 0; i < ROW_BITS; i++) begin
            if (gaps && (i % 37) == 20) begin
                n_d = 1'($urandom); tick();
            end
            if (mode == 0 && i == 0) begin
                n_rs = 1; n_sel = IDX_W'(sel);
            end
            n_v = 1;
            n_d = ones ? 1'b1 : 1'($urandom);
            tick();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] saved;
        logic [7:0]  q[$];
        // R1: reset
        for (int i = 0; i < 3; i++) tick();
        check("R1 done at reset", {31'b0, done}, 32'h0);
        check("R1 crc_out at reset", crc_out, 32'h0);
        n_rst = 1;
        tick();

        // R2: load masks, plus one to an out-of-range index
        cur_tag = "R2";
        for (int k = 0; k < NUM_MASKS; k++) begin
            n_wr = 1; n_widx = IDX_W'(k); n_wdata = mk_mask(k); tick();
        end
        n_wr = 1; n_widx = 3'd7; n_wdata = '1; tick();

        // Run A: mixed selectors, gaps, stray bits, mid-run mask rewrite
        cur_tag = "R12";
        n_start = 1; tick();
        cur_tag = "R8";
        n_v = 1; n_d = 1; tick();
        n_v = 1; n_d = 1; tick();
        for (int r = 0; r < NUM_ROWS; r++) begin
            cur_tag = (r == NUM_ROWS - 1) ? "R10" : "R3";
            if (r == 50) begin
                n_wr = 1; n_widx = 3'd2; n_wdata = mk_mask(9); tick();
            end
            send_row(r % 8, r % 2, 0, 1'b1);
            if (r % 3 == 0) begin
                cur_tag = "R8";
                n_v = 1; n_d = 1; tick();
            end
        end
        tick();
        check("R3 R4 R6 R7 R9 final crc run A", crc_out, m_crc);
        check("R10 done after last row", {31'b0, done}, 32'h1);
        saved = crc_out;
        cur_tag = "R11";
        for (int i = 0; i < 20; i++) begin
            n_rs = (i % 4 == 0); n_sel = IDX_W'(i % 8); n_v = 1; n_d = 1'($urandom); tick();
        end
        tick();
        check("R11 crc held after done", crc_out, saved);
        check("R11 done held", {31'b0, done}, 32'h1);

        // Run B: restart mid-run, start with coincident row bit
        cur_tag = "R12";
        n_start = 1; tick();
        for (int r = 0; r < 10; r++) send_row(r % 6, 0, 0, 1'b0);
        n_start = 1; n_rs = 1; n_sel = 3'd0; n_v = 1; n_d = 1; tick();
        tick();
        check("R12 done cleared by start", {31'b0, done}, 32'h0);
        check("R12 crc reloaded", crc_out, 32'h0);
        cur_tag = "R5";
        for (int r = 0; r < NUM_ROWS; r++) send_row(0, r % 2, 1, 1'b0);
        tick();
        q.delete();
        for (int r = 0; r < NUM_ROWS; r++) begin
            for (int b = 0; b < ROW_BYTES - 1; b++) q.push_back(8'hFF);
            q.push_back(8'h03);
        end
        check("R5 R4 all-ones rows padded", crc_out, crc_of(q));

        // Run C: out-of-range selector zeroes all data
        cur_tag = "R9";
        n_start = 1; tick();
        for (int r = 0; r < NUM_ROWS; r++) send_row(6 + (r % 2), 0, 1, 1'b0);
        tick();
        q.delete();
        for (int i = 0; i < NUM_ROWS * ROW_BYTES; i++) q.push_back(8'h00);
        check("R9 selector 6/7 masks all bits", crc_out, crc_of(q));
        check("R10 done after run C", {31'b0, done}, 32'h1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule